// File: doc/BRIEF.md
# Counterflow Operand-Forwarding Pipeline

This block is an in-order execution pipeline built as a column of stages. Each stage has one instruction slot and one result slot. Instructions climb from the bottom toward a register file at the top, where they retire. Result packets, each a register tag and a value, fall from the top toward the bottom and leave there. When an instruction and a result share a stage, they are compared. A source operand that is still missing is taken from a result whose tag matches it. A result whose tag matches the instruction's destination is rewritten with that instruction's value if it has already computed one, and removed from the stream if it has not. Because of this, every value that reaches an instruction reflects all older writers above it.

Operands that are not forwarded come from the register file. When an instruction is accepted, both of its source tags are queued at the top. The register file then sends their current values down one packet per cycle. A value being written back by a retiring instruction in that same cycle is passed straight through. One stage is the execute stage. An instruction waits there until both operands are held and the result slot it will fill is free. It then computes, drops its result into the falling stream, and carries the same value upward to the register file.

The instruction input is a valid/ready stream. An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high, and the source may not change it while `in_ready` is low. The retire output is also valid/ready. While `ret_valid` is high and `ret_ready` is low, the top instruction stays put and its destination and value hold still. No register is written until the handshake completes.

Top module: `cfp_pipe`

## Requirements
- R1: After reset, `ret_valid` is 0 and `in_ready` is 1, and register k holds (k+1)*0x0101 truncated to the data width.
- R2: The operation field selects 0 = add, 1 = subtract (source0 minus source1), 2 = bitwise and, 3 = bitwise xor, all modulo 2^DW.
- R3: An instruction that reads a register written by an older instruction still in flight receives that older instruction's value. A result and an instruction in adjacent stages never trade places in one cycle: an instruction under a result waits.
- R4: Each accepted instruction retires exactly once, in acceptance order, with its destination on `ret_dst` and its value on `ret_data`. When no instructions are outstanding, `ret_valid` is 0.
- R5: While `ret_valid` is 1 and `ret_ready` is 0, `ret_valid`, `ret_dst` and `ret_data` stay unchanged on the next cycle.
- R6: An instruction is accepted only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is low whenever the top request queue lacks room for two tags, so the queue never overflows.
- R7: An instruction computes only when both source operands are held. No instruction occupies a stage above the execute stage without a computed result.
- R8: An instruction whose destination equals one of its own sources reads the value from before its own write.
- R9: After several back-to-back writes to one register, a later reader gets the value of the newest of those writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Pipeline can take the offered instruction |
| in_op | input | 2 | Operation code (R2) |
| in_src0 | input | $clog2(NREG) | First source register tag |
| in_src1 | input | $clog2(NREG) | Second source register tag |
| in_dst | input | $clog2(NREG) | Destination register tag |
| ret_valid | output | 1 | Top instruction is ready to retire |
| ret_ready | input | 1 | Consumer accepts the retiring instruction |
| ret_dst | output | $clog2(NREG) | Destination of the retiring instruction |
| ret_data | output | DW | Value written to the register file |

## Verification
The assertions assume that `in_valid` and the instruction fields are held steady while `in_ready` is low. They also assume that `ret_ready` may be dropped at any time but never causes a retire to be counted twice. The stimulus changes inputs only a moment after a rising edge and keeps an offered instruction in place until it sees `in_ready` high at the following falling edge. The sweeps cover every pair of source registers under every operation, with a destination that moves across the register set. Some instructions therefore read their own destination, some read the previous instruction's destination, and some read registers not yet written. A final phase throttles `ret_ready` in a repeating pattern while a chain of dependent instructions and repeated writes to one register pass through.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } cfp_op_e;
endpackage

// File: rtl/cfp_cmp.sv
// Per-stage meeting point: an instruction and a result in the same stage
// are compared; sources capture, a matching destination refreshes or kills.
module cfp_cmp #(
  parameter int DW = 16,
  parameter int TW = 3
) (
  input  logic          iv,
  input  logic [TW-1:0] is0,
  input  logic [TW-1:0] is1,
  input  logic [TW-1:0] id,
  input  logic          ir0,
  input  logic          ir1,
  input  logic [DW-1:0] ia0,
  input  logic [DW-1:0] ia1,
  input  logic          idn,
  input  logic [DW-1:0] ires,
  input  logic          rv,
  input  logic [TW-1:0] rtag,
  input  logic [DW-1:0] rdat,
  output logic          or0,
  output logic          or1,
  output logic [DW-1:0] oa0,
  output logic [DW-1:0] oa1,
  output logic          orv,
  output logic [DW-1:0] ordat
);
  logic meet, take0, take1, wr_hit;

  always_comb begin
    meet   = iv & rv;
    take0  = meet & ~ir0 & (rtag == is0);
    take1  = meet & ~ir1 & (rtag == is1);
    wr_hit = meet & (rtag == id);
    or0    = ir0 | take0;
    or1    = ir1 | take1;
    oa0    = take0 ? rdat : ia0;
    oa1    = take1 ? rdat : ia1;
    // a writer above everything further down supersedes the falling value
    orv    = rv & ~(wr_hit & ~idn);
    ordat  = (wr_hit & idn) ? ires : rdat;
  end
endmodule

// File: rtl/cfp_reqq.sv
// Queue of source tags awaiting a register-file value at the top.
module cfp_reqq #(
  parameter int DEPTH = 8,
  parameter int TW    = 3,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push2,
  input  logic [TW-1:0] d0,
  input  logic [TW-1:0] d1,
  input  logic          pop,
  output logic [TW-1:0] q,
  output logic          nonempty,
  output logic          room2
);
  logic [TW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic [PW:0]   cnt_nxt;

  always_comb begin
    q        = mem[rp];
    nonempty = (cnt != '0);
    room2    = (cnt <= (PW+1)'(DEPTH - 2));
    cnt_nxt  = cnt + (push2 ? (PW+1)'(2) : '0) - (pop ? (PW+1)'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push2) begin
        mem[wp]          <= d0;
        mem[wp + PW'(1)] <= d1;
        wp               <= wp + PW'(2);
      end
      if (pop) rp <= rp + PW'(1);
      cnt <= cnt_nxt;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push2 |-> (cnt <= (PW+1)'(DEPTH - 2)));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/cfp_rf.sv
// Register file at the top of the column, with write-through read.
module cfp_rf #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [TW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] regs [NREG];

  always_comb rd = (we && wa == ra) ? wd : regs[ra];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs[k] <= DW'((k + 1) * 257);
    end else if (we) begin
      regs[wa] <= wd;
    end
  end
endmodule

// File: rtl/cfp_pipe.sv
module cfp_pipe
  import cfp_pkg::*;
#(
  parameter int NSTG = 4,
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int EXE  = 2,
  parameter int RQD  = 8,
  localparam int TW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [TW-1:0] in_src0,
  input  logic [TW-1:0] in_src1,
  input  logic [TW-1:0] in_dst,
  output logic          ret_valid,
  input  logic          ret_ready,
  output logic [TW-1:0] ret_dst,
  output logic [DW-1:0] ret_data
);
  // instruction slots
  logic [NSTG-1:0] iv, ir0, ir1, idn;
  cfp_op_e         iop  [NSTG];
  logic [TW-1:0]   is0  [NSTG];
  logic [TW-1:0]   is1  [NSTG];
  logic [TW-1:0]   id   [NSTG];
  logic [DW-1:0]   ia0  [NSTG];
  logic [DW-1:0]   ia1  [NSTG];
  logic [DW-1:0]   ires [NSTG];
  // result slots
  logic [NSTG-1:0] rv;
  logic [TW-1:0]   rtag [NSTG];
  logic [DW-1:0]   rdat [NSTG];

  // after comparison
  logic [NSTG-1:0] c_r0, c_r1, c_rv;
  logic [DW-1:0]   c_a0   [NSTG];
  logic [DW-1:0]   c_a1   [NSTG];
  logic [DW-1:0]   c_rdat [NSTG];

  // movement and next-slot sources
  logic [NSTG-1:0] mv, lo_ld, lo_r0, lo_r1, lo_dn, hi_v;
  cfp_op_e         lo_op  [NSTG];
  logic [TW-1:0]   lo_s0  [NSTG];
  logic [TW-1:0]   lo_s1  [NSTG];
  logic [TW-1:0]   lo_d   [NSTG];
  logic [DW-1:0]   lo_a0  [NSTG];
  logic [DW-1:0]   lo_a1  [NSTG];
  logic [DW-1:0]   lo_res [NSTG];
  logic [TW-1:0]   hi_tag [NSTG];
  logic [DW-1:0]   hi_dat [NSTG];

  logic          acc, ex_fire, ex_free, inj_go, ret_fire;
  logic [DW-1:0] ex_val, rf_rd;
  logic [TW-1:0] q_tag;
  logic          q_ne, q_room2;

  function automatic logic [DW-1:0] alu(cfp_op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      default: return a ^ b;
    endcase
  endfunction

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    cfp_cmp #(.DW(DW), .TW(TW)) u_cmp (
      .iv(iv[g]), .is0(is0[g]), .is1(is1[g]), .id(id[g]),
      .ir0(ir0[g]), .ir1(ir1[g]), .ia0(ia0[g]), .ia1(ia1[g]),
      .idn(idn[g]), .ires(ires[g]),
      .rv(rv[g]), .rtag(rtag[g]), .rdat(rdat[g]),
      .or0(c_r0[g]), .or1(c_r1[g]), .oa0(c_a0[g]), .oa1(c_a1[g]),
      .orv(c_rv[g]), .ordat(c_rdat[g])
    );
  end

  // the execute slot may fill only if nothing falls into it this cycle
  if (EXE == NSTG - 1) begin : g_ex_top
    assign ex_free = 1'b1;
  end else begin : g_ex_mid
    assign ex_free = ~c_rv[EXE+1];
  end

  always_comb begin
    ex_fire = iv[EXE] & ~idn[EXE] & ir0[EXE] & ir1[EXE] & ex_free;
    ex_val  = alu(iop[EXE], ia0[EXE], ia1[EXE]);
    inj_go  = q_ne & ~((EXE == NSTG - 1) & ex_fire);
  end

  // instruction movement: an instruction waits under a falling result
  always_comb begin
    mv[NSTG-1] = iv[NSTG-1] & idn[NSTG-1] & ret_ready;
    for (int i = NSTG - 2; i >= 0; i--) begin
      mv[i] = iv[i] & ((i < EXE) | idn[i]) & (~iv[i+1] | mv[i+1]) & ~c_rv[i+1];
    end
  end

  always_comb begin
    in_ready  = (~iv[0] | mv[0]) & ~c_rv[0] & q_room2;
    acc       = in_valid & in_ready;
    ret_valid = iv[NSTG-1] & idn[NSTG-1];
    ret_dst   = id[NSTG-1];
    ret_data  = ires[NSTG-1];
    ret_fire  = mv[NSTG-1];
  end

  // what arrives in each instruction slot from below
  always_comb begin
    lo_ld[0]  = acc;
    lo_op[0]  = cfp_op_e'(in_op);
    lo_s0[0]  = in_src0;
    lo_s1[0]  = in_src1;
    lo_d[0]   = in_dst;
    lo_r0[0]  = 1'b0;
    lo_r1[0]  = 1'b0;
    lo_a0[0]  = '0;
    lo_a1[0]  = '0;
    lo_dn[0]  = 1'b0;
    lo_res[0] = '0;
    for (int i = 1; i < NSTG; i++) begin
      lo_ld[i]  = mv[i-1];
      lo_op[i]  = iop[i-1];
      lo_s0[i]  = is0[i-1];
      lo_s1[i]  = is1[i-1];
      lo_d[i]   = id[i-1];
      lo_r0[i]  = c_r0[i-1];
      lo_r1[i]  = c_r1[i-1];
      lo_a0[i]  = c_a0[i-1];
      lo_a1[i]  = c_a1[i-1];
      lo_dn[i]  = idn[i-1];
      lo_res[i] = ires[i-1];
    end
  end

  // what arrives in each result slot from above (results never stall)
  always_comb begin
    for (int i = 0; i < NSTG - 1; i++) begin
      hi_v[i]   = c_rv[i+1];
      hi_tag[i] = rtag[i+1];
      hi_dat[i] = c_rdat[i+1];
    end
    hi_v[NSTG-1]   = inj_go;
    hi_tag[NSTG-1] = q_tag;
    hi_dat[NSTG-1] = rf_rd;
    if (ex_fire) begin
      hi_v[EXE]   = 1'b1;
      hi_tag[EXE] = id[EXE];
      hi_dat[EXE] = ex_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv  <= '0;
      ir0 <= '0;
      ir1 <= '0;
      idn <= '0;
      rv  <= '0;
      for (int i = 0; i < NSTG; i++) begin
        iop[i]  <= OP_ADD;
        is0[i]  <= '0;
        is1[i]  <= '0;
        id[i]   <= '0;
        ia0[i]  <= '0;
        ia1[i]  <= '0;
        ires[i] <= '0;
        rtag[i] <= '0;
        rdat[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSTG; i++) begin
        if (lo_ld[i]) begin
          iv[i]   <= 1'b1;
          iop[i]  <= lo_op[i];
          is0[i]  <= lo_s0[i];
          is1[i]  <= lo_s1[i];
          id[i]   <= lo_d[i];
          ir0[i]  <= lo_r0[i];
          ir1[i]  <= lo_r1[i];
          ia0[i]  <= lo_a0[i];
          ia1[i]  <= lo_a1[i];
          idn[i]  <= lo_dn[i];
          ires[i] <= lo_res[i];
        end else begin
          if (mv[i]) iv[i] <= 1'b0;
          ir0[i] <= c_r0[i];
          ir1[i] <= c_r1[i];
          ia0[i] <= c_a0[i];
          ia1[i] <= c_a1[i];
          if (i == EXE && ex_fire) begin
            idn[i]  <= 1'b1;
            ires[i] <= ex_val;
          end
        end
        rv[i]   <= hi_v[i];
        rtag[i] <= hi_tag[i];
        rdat[i] <= hi_dat[i];
      end
    end
  end

  cfp_reqq #(.DEPTH(RQD), .TW(TW)) u_reqq (
    .clk(clk), .rst_n(rst_n),
    .push2(acc), .d0(in_src0), .d1(in_src1),
    .pop(inj_go), .q(q_tag), .nonempty(q_ne), .room2(q_room2)
  );

  cfp_rf #(.NREG(NREG), .DW(DW), .TW(TW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(ret_fire), .wa(ret_dst), .wd(ret_data),
    .ra(q_tag), .rd(rf_rd)
  );

  // ---------------- assertions ----------------
  for (genvar g = 0; g < NSTG; g++) begin : g_chk
    assert_done_has_ops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (iv[g] && idn[g]) |-> (ir0[g] && ir1[g]));
    if (g > EXE) begin : g_above
      assert_above_exe_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iv[g] |-> idn[g]);
    end
    if (g < NSTG - 1) begin : g_noswap
      assert_no_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iv[g] && c_rv[g+1]) |=> iv[g]);
    end
  end

  assert_ret_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_dst) && $stable(ret_data)));

  assert_exec_needs_ops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire |=> (idn[EXE] && ir0[EXE] && ir1[EXE]));
endmodule

// File: tb/cfp_pipe_test.sv
`timescale 1ns/100ps
module cfp_pipe_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [2:0]  in_src0 = '0;
  logic [2:0]  in_src1 = '0;
  logic [2:0]  in_dst = '0;
  logic        ret_valid;
  logic        ret_ready = 1'b1;
  logic [2:0]  ret_dst;
  logic [15:0] ret_data;

  always #2.5 clk = ~clk;

  cfp_pipe #(.NSTG(4), .NREG(8), .DW(16), .EXE(2), .RQD(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_src0(in_src0), .in_src1(in_src1), .in_dst(in_dst),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_dst(ret_dst), .ret_data(ret_data)
  );

  int n_chk = 0, n_bad = 0;
  int n_push = 0, n_ret = 0;
  int cyc = 0;
  bit rr_mode = 1'b0;
  bit finished = 1'b0;
  logic [15:0] mdl [8];
  bit          written [8];
  logic [2:0]  last_dst;
  bit          have_last = 1'b0;
  logic [2:0]  exp_d [1024];
  logic [15:0] exp_v [1024];
  string       exp_t [1024];
  bit          hold_prev = 1'b0;
  logic [2:0]  hold_d;
  logic [15:0] hold_v;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_op(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic issue(int op, int a, int b, int d, string ovr);
    string t;
    if (ovr != "") t = ovr;
    else if (a == d || b == d) t = "R8";
    else if (have_last && (last_dst == 3'(a) || last_dst == 3'(b))) t = "R3";
    else if (!written[a] && !written[b]) t = "R1";
    else t = "R4";
    exp_t[n_push] = {t, " R2 R7"};
    exp_v[n_push] = ref_op(op, mdl[a], mdl[b]);
    exp_d[n_push] = 3'(d);
    mdl[d] = exp_v[n_push];
    written[d] = 1'b1;
    last_dst = 3'(d);
    have_last = 1'b1;
    n_push++;
    in_valid = 1'b1;
    in_op = 2'(op);
    in_src0 = 3'(a);
    in_src1 = 3'(b);
    in_dst = 3'(d);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    ret_ready = rr_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // retire monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev)
        chk(ret_valid && ret_dst == hold_d && ret_data == hold_v, "R5 held retire",
            {13'd0, ret_dst, ret_data}, {13'd0, hold_d, hold_v});
      hold_prev = ret_valid && !ret_ready;
      hold_d = ret_dst;
      hold_v = ret_data;
      if (ret_valid && ret_ready) begin
        if (n_ret < n_push)
          chk(ret_dst == exp_d[n_ret] && ret_data == exp_v[n_ret], exp_t[n_ret],
              {13'd0, ret_dst, ret_data}, {13'd0, exp_d[n_ret], exp_v[n_ret]});
        else
          chk(1'b0, "R4 extra retire", n_ret, n_push);
        n_ret++;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d retires", n_ret, n_push);
    summary();
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      mdl[k] = 16'((k + 1) * 257);
      written[k] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ret_valid == 1'b0, "R1 ret_valid in reset", ret_valid, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ret_valid == 1'b0, "R1 ret_valid after reset", ret_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    @(posedge clk);
    #1;
    // sweep every source pair under every operation
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          issue(op, a, b, (a * 3 + b + op) % 8, "");
    // throttled retire with dependence chains and repeated writes
    rr_mode = 1'b1;
    issue(0, 1, 2, 5, "R9");
    issue(1, 5, 3, 5, "R9");
    issue(3, 5, 5, 5, "R9");
    issue(0, 5, 0, 6, "R9");
    for (int k = 0; k < 32; k++)
      issue(k % 4, k % 8, (k + 1) % 8, (k + 2) % 8, "");
    for (int k = 0; k < 2000 && n_ret < n_push; k++) @(negedge clk);
    chk(n_ret == n_push, "R4 R6 retire count", n_ret, n_push);
    repeat (4) @(negedge clk);
    chk(ret_valid == 1'b0, "R4 idle ret_valid", ret_valid, 0);
    summary();
  end
endmodule